// File: doc/BRIEF.md
# Strided Memory Access Sequencer

The sequencer sits in front of a word-addressed synchronous RAM. It turns single commands into runs of RAM accesses and returns every result on one output channel. A command is one of three things: a read address, a write address, or a packed fetch descriptor. Each step of a run performs one access, lowers the remaining count by one and advances the address by the stride. Read steps return the stored word. Write steps consume one write-data token and return the address that the next write of the run will use.

Stride and count tokens can be queued ahead of a read or write command. They replace the defaults (stride 0, count 1) for that one command only. A fetch descriptor always uses stride 1, and it takes its start address and word count from fixed fields of the word. Every channel uses a valid/ready handshake. The RAM registers its read address, so the sequencer captures read data on the clock that follows the access.

Top module: `mem_stride_seq`

## Requirements
- R1: After reset, out_valid_o is 0, wr_data_ready_o is 0, and desc_ready_o and rd_addr_ready_o are 1.
- R2: A read address with no queued stride or count returns exactly one word, the one stored at that address.
- R3: A write address with no queued stride or count writes one data token to that address and acknowledges with the same address, because the stride is 0.
- R4: A stride or count token applies only to the first read or write command accepted in a later cycle. The command after that uses stride 0 and count 1 again.
- R5: A read run with stride S and count N returns the words at A, A+S, ..., A+(N-1)S, in that order.
- R6: A write run stores its k-th data token at A+kS. For each stored token it outputs the address of the next write, A+(k+1)S, zero-extended to the data width.
- R7: A descriptor holds the start address in bits [DATA_W-1:LEN_W] and the word count in bits [LEN_W-1:0] (bits 36..6 and 5..0 by default). It reads count words from consecutive addresses, starting at the start address.
- R8: A descriptor with count 0 produces no output, and the sequencer accepts new commands again on the next cycle.
- R9: Commands are accepted only when no run is in progress. When several commands are offered at once, a descriptor goes first, then a read address, then a write address.
- R10: While out_valid_o is 1 and out_ready_i is 0, out_o and out_valid_o stay unchanged.
- R11: Addresses wrap modulo the RAM depth (2^ADDR_W words). Descriptor address bits above ADDR_W are dropped.
- R12: A write-data token is consumed only during a write step. While the sequencer is idle, wr_data_ready_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_addr_i | input | ADDR_W | Read start address |
| rd_addr_valid_i | input | 1 | Read address valid |
| rd_addr_ready_o | output | 1 | Read address accepted |
| wr_addr_i | input | ADDR_W | Write start address |
| wr_addr_valid_i | input | 1 | Write address valid |
| wr_addr_ready_o | output | 1 | Write address accepted |
| wr_data_i | input | DATA_W | Write data token |
| wr_data_valid_i | input | 1 | Write data valid |
| wr_data_ready_o | output | 1 | Write data consumed |
| stride_i | input | ADDR_W | Stride for the next read or write command |
| stride_valid_i | input | 1 | Stride valid |
| stride_ready_o | output | 1 | Stride accepted |
| count_i | input | CNT_W | Count for the next read or write command |
| count_valid_i | input | 1 | Count valid |
| count_ready_o | output | 1 | Count accepted |
| desc_i | input | DATA_W | Fetch descriptor (start address, word count) |
| desc_valid_i | input | 1 | Descriptor valid |
| desc_ready_o | output | 1 | Descriptor accepted |
| out_o | output | DATA_W | Read word or write acknowledge |
| out_valid_o | output | 1 | Output valid |
| out_ready_i | input | 1 | Output accepted downstream |

## Verification
The bench offers a descriptor, a read address and a write address in the same cycle. If the priority were wrong or a command were accepted mid-run, the acknowledge and the read words would come back interleaved or out of order. It follows a run with a second command that has no queued stride or count. A sequencer that kept the old stride would acknowledge a write with the wrong address. It holds the output stalled in the middle of a run: a design that kept stepping would lose a captured read word or change out_o under a stall. A write run that crosses the top of the RAM, a descriptor with high address bits, a descriptor with count 0, and a write-data token offered while idle probe the wrap, truncation, empty-run and token-consumption rules.

// File: rtl/stride_seq_pkg.sv
package stride_seq_pkg;
  typedef enum logic [1:0] {
    GNT_NONE,
    GNT_DESC,
    GNT_RD,
    GNT_WR
  } gnt_e;
endpackage

// File: rtl/stride_seq_arb.sv
module stride_seq_arb
  import stride_seq_pkg::*;
(
  input  logic idle_i,
  input  logic desc_v_i,
  input  logic rd_v_i,
  input  logic wr_v_i,
  output gnt_e gnt_o,
  output logic desc_rdy_o,
  output logic rd_rdy_o,
  output logic wr_rdy_o
);
  // fixed priority: descriptor, read, write; only between runs
  assign desc_rdy_o = idle_i;
  assign rd_rdy_o   = idle_i & ~desc_v_i;
  assign wr_rdy_o   = idle_i & ~desc_v_i & ~rd_v_i;

  always_comb begin
    gnt_o = GNT_NONE;
    if (idle_i) begin
      if (desc_v_i)    gnt_o = GNT_DESC;
      else if (rd_v_i) gnt_o = GNT_RD;
      else if (wr_v_i) gnt_o = GNT_WR;
    end
  end
endmodule

// File: rtl/stride_seq_ram.sv
module stride_seq_ram #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 37
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [ADDR_W-1:0] raddr_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    raddr_q <= addr_i;
  end

  assign rdata_o = mem_q[raddr_q];
endmodule

// File: rtl/mem_stride_seq.sv
module mem_stride_seq
  import stride_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 37,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned LEN_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              rd_addr_valid_i,
  output logic              rd_addr_ready_o,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              wr_addr_valid_i,
  output logic              wr_addr_ready_o,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_data_valid_i,
  output logic              wr_data_ready_o,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic              stride_valid_i,
  output logic              stride_ready_o,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              count_valid_i,
  output logic              count_ready_o,
  input  logic [DATA_W-1:0] desc_i,
  input  logic              desc_valid_i,
  output logic              desc_ready_o,
  output logic [DATA_W-1:0] out_o,
  output logic              out_valid_o,
  input  logic              out_ready_i
);
  localparam int unsigned BASE_W = DATA_W - LEN_W;

  logic [ADDR_W-1:0] addr_q, stride_q, stride_hold_q;
  logic [CNT_W-1:0]  cnt_q, cnt_hold_q;
  logic              wr_mode_q, rd_pend_q, stride_pend_q, cnt_pend_q;
  logic [DATA_W-1:0] out_q, ram_rdata;
  logic              out_vld_q;

  gnt_e              gnt;
  logic              idle, out_free, rd_step, wr_step, step, take_opt;
  logic [ADDR_W-1:0] addr_nxt, cmd_addr, desc_base;
  logic [CNT_W-1:0]  desc_len;

  assign idle     = (cnt_q == '0);
  assign out_free = ~out_vld_q | out_ready_i;
  // a read is issued only if the slot will be free when its data lands
  assign rd_step  = ~idle & ~wr_mode_q & ~rd_pend_q & out_free;
  assign wr_step  = ~idle & wr_mode_q & ~rd_pend_q & wr_data_valid_i & out_free;
  assign step     = rd_step | wr_step;
  assign addr_nxt = addr_q + stride_q;

  assign desc_base = ADDR_W'(desc_i[DATA_W-1:LEN_W]);
  assign desc_len  = CNT_W'(desc_i[LEN_W-1:0]);
  assign cmd_addr  = (gnt == GNT_WR) ? wr_addr_i : rd_addr_i;
  assign take_opt  = (gnt == GNT_RD) | (gnt == GNT_WR);

  stride_seq_arb i_arb (
    .idle_i    (idle),
    .desc_v_i  (desc_valid_i),
    .rd_v_i    (rd_addr_valid_i),
    .wr_v_i    (wr_addr_valid_i),
    .gnt_o     (gnt),
    .desc_rdy_o(desc_ready_o),
    .rd_rdy_o  (rd_addr_ready_o),
    .wr_rdy_o  (wr_addr_ready_o)
  );

  stride_seq_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ram (
    .clk_i  (clk_i),
    .we_i   (wr_step),
    .addr_i (addr_q),
    .wdata_i(wr_data_i),
    .rdata_o(ram_rdata)
  );

  // run state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q    <= '0;
      stride_q  <= '0;
      cnt_q     <= '0;
      wr_mode_q <= 1'b0;
      rd_pend_q <= 1'b0;
    end else begin
      rd_pend_q <= rd_step;
      unique case (gnt)
        GNT_DESC: begin
          addr_q    <= desc_base;
          stride_q  <= ADDR_W'(1);
          cnt_q     <= desc_len;
          wr_mode_q <= 1'b0;
        end
        GNT_RD, GNT_WR: begin
          addr_q    <= cmd_addr;
          stride_q  <= stride_pend_q ? stride_hold_q : '0;
          cnt_q     <= cnt_pend_q ? cnt_hold_q : CNT_W'(1);
          wr_mode_q <= (gnt == GNT_WR);
        end
        default: begin
          if (step) begin
            addr_q <= addr_nxt;
            cnt_q  <= cnt_q - CNT_W'(1);
          end
        end
      endcase
    end
  end

  // one-shot stride/count overrides
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stride_pend_q <= 1'b0;
      stride_hold_q <= '0;
      cnt_pend_q    <= 1'b0;
      cnt_hold_q    <= '0;
    end else begin
      if (stride_valid_i && !stride_pend_q) begin
        stride_pend_q <= 1'b1;
        stride_hold_q <= stride_i;
      end else if (take_opt) begin
        stride_pend_q <= 1'b0;
      end
      if (count_valid_i && !cnt_pend_q) begin
        cnt_pend_q <= 1'b1;
        cnt_hold_q <= count_i;
      end else if (take_opt) begin
        cnt_pend_q <= 1'b0;
      end
    end
  end

  // output register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q     <= '0;
      out_vld_q <= 1'b0;
    end else if (rd_pend_q) begin
      out_q     <= ram_rdata;
      out_vld_q <= 1'b1;
    end else if (wr_step) begin
      out_q     <= DATA_W'(addr_nxt);
      out_vld_q <= 1'b1;
    end else if (out_ready_i) begin
      out_vld_q <= 1'b0;
    end
  end

  assign out_o           = out_q;
  assign out_valid_o     = out_vld_q;
  assign wr_data_ready_o = wr_step;
  assign stride_ready_o  = ~stride_pend_q;
  assign count_ready_o   = ~cnt_pend_q;

  if (BASE_W < ADDR_W) begin : g_bad_width
    initial $error("descriptor base field narrower than address");
  end
endmodule

// File: rtl/mem_stride_seq_chk.sv
module mem_stride_seq_chk #(
  parameter int unsigned DATA_W = 37
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_addr_valid_i,
  input logic              rd_addr_ready_o,
  input logic              wr_addr_valid_i,
  input logic              wr_addr_ready_o,
  input logic              wr_data_valid_i,
  input logic              wr_data_ready_o,
  input logic              desc_valid_i,
  input logic              desc_ready_o,
  input logic [DATA_W-1:0] out_o,
  input logic              out_valid_o,
  input logic              out_ready_i
);
  p_out_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_o));

  p_one_cmd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({desc_valid_i && desc_ready_o, rd_addr_valid_i && rd_addr_ready_o,
              wr_addr_valid_i && wr_addr_ready_o}));

  p_desc_first_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_i |-> !rd_addr_ready_o && !wr_addr_ready_o);

  p_rd_over_wr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_addr_valid_i |-> !wr_addr_ready_o);

  p_wdata_room_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data_valid_i && wr_data_ready_o |-> !out_valid_o || out_ready_i);

  p_wr_ack_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data_valid_i && wr_data_ready_o |=> out_valid_o);

  p_idle_no_wdata_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_ready_o |-> !wr_data_ready_o);
endmodule

bind mem_stride_seq mem_stride_seq_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .rd_addr_valid_i(rd_addr_valid_i),
  .rd_addr_ready_o(rd_addr_ready_o),
  .wr_addr_valid_i(wr_addr_valid_i),
  .wr_addr_ready_o(wr_addr_ready_o),
  .wr_data_valid_i(wr_data_valid_i),
  .wr_data_ready_o(wr_data_ready_o),
  .desc_valid_i   (desc_valid_i),
  .desc_ready_o   (desc_ready_o),
  .out_o          (out_o),
  .out_valid_o    (out_valid_o),
  .out_ready_i    (out_ready_i)
);

// File: tb/test_mem_stride_seq.sv
`timescale 1ns/1ps
module test_mem_stride_seq;
  localparam int unsigned ADDR_W = 10;
  localparam int unsigned DATA_W = 37;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned LEN_W  = 6;
  localparam int unsigned BASE_W = DATA_W - LEN_W;
  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam time         CLK_P  = 20ns;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [ADDR_W-1:0] rd_addr_i = '0, wr_addr_i = '0, stride_i = '0;
  logic rd_addr_valid_i = 0, wr_addr_valid_i = 0, wr_data_valid_i = 0;
  logic stride_valid_i = 0, count_valid_i = 0, desc_valid_i = 0, out_ready_i = 1;
  logic [DATA_W-1:0] wr_data_i = '0, desc_i = '0;
  logic [CNT_W-1:0]  count_i = '0;
  logic rd_addr_ready_o, wr_addr_ready_o, wr_data_ready_o, stride_ready_o;
  logic count_ready_o, desc_ready_o, out_valid_o;
  logic [DATA_W-1:0] out_o;

  always #(CLK_P/2) clk = ~clk;

  mem_stride_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .LEN_W(LEN_W))
  i_mem_stride_seq (
    .clk_i(clk), .rst_ni(rst_ni),
    .rd_addr_i(rd_addr_i), .rd_addr_valid_i(rd_addr_valid_i), .rd_addr_ready_o(rd_addr_ready_o),
    .wr_addr_i(wr_addr_i), .wr_addr_valid_i(wr_addr_valid_i), .wr_addr_ready_o(wr_addr_ready_o),
    .wr_data_i(wr_data_i), .wr_data_valid_i(wr_data_valid_i), .wr_data_ready_o(wr_data_ready_o),
    .stride_i(stride_i), .stride_valid_i(stride_valid_i), .stride_ready_o(stride_ready_o),
    .count_i(count_i), .count_valid_i(count_valid_i), .count_ready_o(count_ready_o),
    .desc_i(desc_i), .desc_valid_i(desc_valid_i), .desc_ready_o(desc_ready_o),
    .out_o(out_o), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [DATA_W-1:0] mdl [DEPTH];
  logic [DATA_W-1:0] exp_q [$];
  string             tag_q [$];

  task automatic chk(input bit ok, input string req, input logic [DATA_W-1:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [DATA_W-1:0] v, input string req);
    exp_q.push_back(v);
    tag_q.push_back(req);
  endtask

  // monitor / scoreboard, sampled mid low phase
  bit stall_seen = 0;
  logic [DATA_W-1:0] stall_val;
  always @(negedge clk) begin
    #5;
    if (rst_ni) begin
      if (stall_seen)
        chk(out_valid_o && out_o == stall_val, "R10 stall hold", out_o, stall_val);
      stall_seen = out_valid_o && !out_ready_i;
      stall_val  = out_o;
      if (out_valid_o && out_ready_i) begin
        if (exp_q.size() == 0) chk(0, "unexpected output", out_o, '0);
        else begin
          logic [DATA_W-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(out_o === e, t, out_o, e);
        end
      end
    end
  end

  task automatic send_rd(input logic [ADDR_W-1:0] a);
    rd_addr_i = a; rd_addr_valid_i = 1; #1;
    while (!rd_addr_ready_o) begin @(negedge clk); #1; end
    @(negedge clk); rd_addr_valid_i = 0;
  endtask

  task automatic send_wr(input logic [ADDR_W-1:0] a);
    wr_addr_i = a; wr_addr_valid_i = 1; #1;
    while (!wr_addr_ready_o) begin @(negedge clk); #1; end
    @(negedge clk); wr_addr_valid_i = 0;
  endtask

  task automatic send_wd(input logic [DATA_W-1:0] d);
    wr_data_i = d; wr_data_valid_i = 1; #1;
    while (!wr_data_ready_o) begin @(negedge clk); #1; end
    @(negedge clk); wr_data_valid_i = 0;
  endtask

  task automatic send_stride(input logic [ADDR_W-1:0] s);
    stride_i = s; stride_valid_i = 1; #1;
    while (!stride_ready_o) begin @(negedge clk); #1; end
    @(negedge clk); stride_valid_i = 0;
  endtask

  task automatic send_count(input logic [CNT_W-1:0] c);
    count_i = c; count_valid_i = 1; #1;
    while (!count_ready_o) begin @(negedge clk); #1; end
    @(negedge clk); count_valid_i = 0;
  endtask

  task automatic send_desc(input logic [BASE_W-1:0] b, input logic [LEN_W-1:0] n);
    desc_i = {b, n}; desc_valid_i = 1; #1;
    while (!desc_ready_o) begin @(negedge clk); #1; end
    @(negedge clk); desc_valid_i = 0;
  endtask

  task automatic opts(input logic [ADDR_W-1:0] s, input int n);
    if (!(s == 0 && n == 1)) begin
      send_stride(s);
      send_count(CNT_W'(n));
    end
  endtask

  task automatic wr_run(input logic [ADDR_W-1:0] a, s, input int n,
                        input logic [DATA_W-1:0] d0, input string req);
    opts(s, n);
    for (int i = 0; i < n; i++) begin
      logic [ADDR_W-1:0] aa, nx;
      aa = a + s * ADDR_W'(i);
      nx = aa + s;
      mdl[aa] = d0 + DATA_W'(i);
      push(DATA_W'(nx), req);
    end
    fork
      send_wr(a);
      begin
        for (int i = 0; i < n; i++) send_wd(d0 + DATA_W'(i));
      end
    join
  endtask

  task automatic rd_run(input logic [ADDR_W-1:0] a, s, input int n, input string req);
    opts(s, n);
    for (int i = 0; i < n; i++) push(mdl[a + s * ADDR_W'(i)], req);
    send_rd(a);
  endtask

  task automatic desc_run(input logic [BASE_W-1:0] b, input int n, input string req);
    for (int i = 0; i < n; i++) push(mdl[ADDR_W'(b) + ADDR_W'(i)], req);
    send_desc(b, LEN_W'(n));
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, req, DATA_W'(exp_q.size()), '0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk); #1;
    // R1 reset state
    chk(!out_valid_o, "R1 out_valid", DATA_W'(out_valid_o), '0);
    chk(!wr_data_ready_o, "R1 wr_data_ready", DATA_W'(wr_data_ready_o), '0);
    chk(desc_ready_o && rd_addr_ready_o, "R1 cmd ready",
        DATA_W'({desc_ready_o, rd_addr_ready_o}), DATA_W'(3));
    @(negedge clk);

    // R3 single write, ack equals address
    wr_run(10'd5, 10'd0, 1, 37'h1_2345_6789, "R3 single write ack");
    // R6 + R4 strided write run, then defaults return
    wr_run(10'd10, 10'd1, 8, 37'h100, "R6 burst write ack");
    wr_run(10'd40, 10'd0, 1, 37'h0_dead_beef, "R4 defaults after override");
    drain("R6 drain");

    // R2 single reads
    rd_run(10'd5, 10'd0, 1, "R2 single read");
    rd_run(10'd40, 10'd0, 1, "R2 single read");
    // R5 stride 2 read run, R4 next read back to single
    rd_run(10'd10, 10'd2, 4, "R5 strided read");
    rd_run(10'd17, 10'd0, 1, "R4 single after burst");
    drain("R5 drain");

    // R7 + R11 descriptor with address bits above ADDR_W
    desc_run(BASE_W'(32'h0010_0000 + 32'd10), 3, "R7 descriptor read");
    drain("R7 drain");

    // R8 empty descriptor
    send_desc(BASE_W'(12), '0);
    #1;
    chk(desc_ready_o, "R8 ready after empty", DATA_W'(desc_ready_o), DATA_W'(1));
    repeat (4) begin @(negedge clk); #1;
      chk(!out_valid_o, "R8 no output", DATA_W'(out_valid_o), '0);
    end
    @(negedge clk);

    // R11 write run across the top of the RAM, read back by descriptor
    wr_run(ADDR_W'(DEPTH - 2), 10'd1, 3, 37'h7_0000_0000, "R11 wrap write ack");
    drain("R11 drain");
    desc_run(BASE_W'(DEPTH - 2), 3, "R11 wrap read");
    drain("R11 read drain");

    // R10 + R9 stall mid-run
    out_ready_i = 0;
    rd_run(10'd10, 10'd1, 3, "R10 stalled read");
    repeat (6) @(negedge clk);
    #1;
    chk(out_valid_o, "R10 held valid", DATA_W'(out_valid_o), DATA_W'(1));
    chk(!rd_addr_ready_o && !desc_ready_o, "R9 busy blocks cmds",
        DATA_W'({rd_addr_ready_o, desc_ready_o}), '0);
    @(negedge clk);
    out_ready_i = 1;
    drain("R10 drain");

    // R9 three commands in the same cycle
    push(mdl[10], "R9 desc first");
    push(mdl[11], "R9 desc first");
    push(mdl[5], "R9 read second");
    push(DATA_W'(50), "R9 write last");
    mdl[50] = 37'h0_0505_0505;
    fork
      send_desc(BASE_W'(10), LEN_W'(2));
      send_rd(10'd5);
      send_wr(10'd50);
      send_wd(37'h0_0505_0505);
    join
    drain("R9 drain");
    rd_run(10'd50, 10'd0, 1, "R9 write landed");
    drain("R9 read drain");

    // R12 write data offered while idle is not consumed
    wr_data_i = 37'h1_1111_0000;
    wr_data_valid_i = 1;
    repeat (4) begin @(negedge clk); #1;
      chk(!wr_data_ready_o, "R12 idle data held", DATA_W'(wr_data_ready_o), '0);
    end
    @(negedge clk);
    mdl[60] = 37'h1_1111_0000;
    push(DATA_W'(60), "R12 token used by write");
    fork
      send_wr(10'd60);
      send_wd(37'h1_1111_0000);
    join
    rd_run(10'd60, 10'd0, 1, "R12 data stored");
    drain("R12 drain");

    finish_run();
  end
endmodule